// File: doc/BRIEF.md
# Period-Timed Frequency to Code Converter

This block measures the frequency of a pulse train by timing a whole number of its cycles against the block clock. It then maps that frequency onto a 12-bit code for a downstream DAC. The raw input first passes a two-flop synchronizer and a programmable debounce filter, so relay chatter and short spikes produce no extra edges. The block starts timing at one accepted rising edge. It keeps counting cycles and clock ticks until a later accepted rising edge closes a span of at least the configured minimum time. That edge both ends the current measurement and starts the next.

From the captured cycle count and tick count the block computes the frequency in Hz as cycles × CLK_HZ / ticks, using a shared multi-cycle restoring divider. It then scales the frequency linearly into the window set by a programmable lower and upper frequency. A frequency below the window gives code 0 with an under-range flag. A frequency above it gives the full-scale code with an over-range flag. If no accepted rising edge arrives for a programmable number of clock cycles, the block reports zero frequency. Each new result is announced by a one-cycle strobe, and the outputs hold their values between strobes.

Top module: `freq_code_conv`

## Requirements
- R1: A measurement spans a whole number N of input cycles, from one accepted rising edge to a later one. N is the smallest count whose total ticks reach `cfg_min_period` clock cycles. The closing edge also opens the next measurement.
- R2: The measured frequency is floor(N × CLK_HZ / ticks), where ticks is the number of clock cycles between the opening and closing edges.
- R3: For `cfg_fmin` ≤ f ≤ `cfg_fmax`, `code` = floor((f − fmin) × 4095 / (fmax − fmin)) and both flags are 0. This gives code 0 at f = fmin and code 4095 at f = fmax.
- R4: For f < `cfg_fmin`, `code` is 0, `under_range` is 1 and `over_range` is 0.
- R5: For f > `cfg_fmax`, `code` is 4095, `over_range` is 1 and `under_range` is 0.
- R6: A level change on `pulse_in` is accepted only after the new level has held for `cfg_debounce` consecutive clock cycles. Pulses shorter than that do not change the measured frequency. If both half-periods are shorter than that, no edge is accepted at all.
- R7: If no rising edge is accepted for `cfg_timeout` clock cycles, the block reports code 0 with `under_range` = 1 and `over_range` = 0, and repeats this report every `cfg_timeout` cycles while the input stays quiet.
- R8: `code_valid` is high for exactly one cycle per result. `code`, `under_range` and `over_range` change only in a cycle where `code_valid` is high.
- R9: While reset is held and after its release, until the first result: `code` = 0, `code_valid` = 0, `under_range` = 0, `over_range` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Raw asynchronous pulse train |
| cfg_debounce | input | DB_W (16) | Clock cycles a new level must hold before it is accepted |
| cfg_min_period | input | TICK_W (24) | Minimum span of one measurement, in clock cycles |
| cfg_timeout | input | TICK_W (24) | Quiet time without an accepted rising edge before a zero report, in clock cycles |
| cfg_fmin | input | FREQ_W (24) | Frequency in Hz mapped to code 0 |
| cfg_fmax | input | FREQ_W (24) | Frequency in Hz mapped to the full-scale code |
| code | output | CODE_W (12) | Scaled frequency code |
| code_valid | output | 1 | One-cycle strobe marking a new result |
| under_range | output | 1 | Frequency below the window, or no input |
| over_range | output | 1 | Frequency above the window |

## Verification
Faults inside the block appear at the ports in three ways. A wrong tick or cycle count in the period meter shows up as a wrong code on the very next strobe. A mis-set debounce counter moves edges unevenly or invents extra ones, so the code drifts or jumps within one or two measurements. A stuck sequencer or divider shows up as missing strobes, or as outputs that change between strobes within one measurement span. The bench predicts every code from the input period and the configuration, and compares each strobe against that prediction. On every other clock it checks that the outputs have held their last values. Boundary windows (f exactly at fmin or fmax), chatter, debounce wider than a half-period and a silent input are each driven as a separate phase.

// File: rtl/fcc_pkg.sv
// Shared types for the frequency to code converter.
// Assumes nothing beyond a single clock domain.
package fcc_pkg;

    // Result sequencer phases
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FREQ  = 2'd1,
        SEQ_SCALE = 2'd2,
        SEQ_OUT   = 2'd3
    } fcc_seq_e;

endpackage

// File: rtl/fcc_debounce.sv
// Synchronizes the raw pulse input and accepts a new level only after it has
// held for hold_cycles consecutive clocks. Emits a one-cycle rise pulse on
// each accepted low-to-high change. Assumes hold_cycles is static while
// the input is being measured; a value of 0 behaves as 1.
module fcc_debounce #(
    parameter int DB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_in,
    input  logic [DB_W-1:0] hold_cycles,
    output logic            level,
    output logic            rise
);

    logic [1:0]      sync_q;
    logic [DB_W-1:0] hold_cnt;
    logic [DB_W:0]   hold_nxt;

    assign hold_nxt = {1'b0, hold_cnt} + 1'b1;

    // Two-flop synchronizer for the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], raw_in};
    end

    // Hold counter: accept the synchronized level once it has been steady long enough
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            level    <= 1'b0;
            rise     <= 1'b0;
        end else begin
            rise <= 1'b0;
            if (sync_q[1] == level) begin
                hold_cnt <= '0;
            end else if (hold_nxt >= {1'b0, hold_cycles}) begin
                level    <= sync_q[1];
                rise     <= sync_q[1];
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_nxt[DB_W-1:0];
            end
        end
    end

    // R6: the accepted level only ever moves to the level the synchronizer showed
    a_r6_level_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(sync_q[1]) == level));

    // R6: a rise pulse marks exactly a low-to-high change of the accepted level
    a_r6_rise_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (level && !$past(level)));

endmodule

// File: rtl/fcc_period_meter.sv
// Times whole input cycles between accepted rising edges. When an edge closes
// a span of at least min_ticks clocks (or the cycle counter is full) it
// reports the cycle and tick counts, and that edge opens the next span.
// A quiet input for timeout_ticks clocks raises timeout_pulse and disarms.
// Assumes rise pulses are single-cycle.
module fcc_period_meter #(
    parameter int TICK_W = 24,
    parameter int CYC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic [TICK_W-1:0] min_ticks,
    input  logic [TICK_W-1:0] timeout_ticks,
    output logic              meas_valid,
    output logic [CYC_W-1:0]  meas_cycles,
    output logic [TICK_W-1:0] meas_ticks,
    output logic              timeout_pulse
);

    localparam logic [CYC_W-1:0] CYC_FULL = '1;

    logic              armed;
    logic [TICK_W-1:0] tick_cnt;
    logic [CYC_W-1:0]  cyc_cnt;
    logic [TICK_W-1:0] idle_cnt;
    logic [TICK_W-1:0] tick_inc;
    logic [CYC_W-1:0]  cyc_inc;
    logic [TICK_W:0]   idle_inc;
    logic              span_done;

    // Saturating increments and the span-complete decision
    always_comb begin
        tick_inc  = (tick_cnt == '1) ? tick_cnt : tick_cnt + 1'b1;
        cyc_inc   = (cyc_cnt == CYC_FULL) ? cyc_cnt : cyc_cnt + 1'b1;
        idle_inc  = {1'b0, idle_cnt} + 1'b1;
        span_done = (tick_inc >= min_ticks) || (cyc_inc == CYC_FULL);
    end

    // Span timing, edge counting and quiet-input detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed         <= 1'b0;
            tick_cnt      <= '0;
            cyc_cnt       <= '0;
            idle_cnt      <= '0;
            meas_valid    <= 1'b0;
            meas_cycles   <= '0;
            meas_ticks    <= '0;
            timeout_pulse <= 1'b0;
        end else begin
            meas_valid    <= 1'b0;
            timeout_pulse <= 1'b0;
            if (rise) begin
                idle_cnt <= '0;
                if (!armed || span_done) begin
                    tick_cnt <= '0;
                    cyc_cnt  <= '0;
                    armed    <= 1'b1;
                end else begin
                    tick_cnt <= tick_inc;
                    cyc_cnt  <= cyc_inc;
                end
                if (armed && span_done) begin
                    meas_valid  <= 1'b1;
                    meas_cycles <= cyc_inc;
                    meas_ticks  <= tick_inc;
                end
            end else begin
                tick_cnt <= tick_inc;
                if (idle_inc >= {1'b0, timeout_ticks}) begin
                    timeout_pulse <= 1'b1;
                    idle_cnt      <= '0;
                    armed         <= 1'b0;
                end else begin
                    idle_cnt <= idle_inc[TICK_W-1:0];
                end
            end
        end
    end

    // R1: a reported span reaches the minimum time unless the cycle count saturated
    a_r1_span_long_enough: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> ((meas_ticks >= $past(min_ticks)) || (meas_cycles == CYC_FULL)));

    // R1: a span always holds at least one whole cycle
    a_r1_whole_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> (meas_cycles != '0));

    // R7: a quiet-input report never coincides with a measurement
    a_r7_timeout_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout_pulse && meas_valid));

endmodule

// File: rtl/fcc_divider.sv
// Unsigned restoring divider producing one quotient bit per clock.
// A start pulse loads the operands; done pulses W+1 clocks later with the
// quotient held until the next start. Assumes start is not raised while
// a division is in progress and the divisor is nonzero.
module fcc_divider #(
    parameter int W = 44
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);

    localparam int CNT_W = $clog2(W + 1);

    logic [W:0]       rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     dvs_q;
    logic [W-1:0]     dvd_q;
    logic [CNT_W-1:0] step_q;
    logic             busy_q;
    logic [W:0]       shifted;
    logic [W:0]       trial;

    assign shifted  = {rem_q[W-1:0], quo_q[W-1]};
    assign trial    = shifted - {1'b0, dvs_q};
    assign quotient = quo_q;

    // One restoring step per clock while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            dvd_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                dvs_q  <= divisor;
                dvd_q  <= dividend;
                step_q <= CNT_W'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (!trial[W]) begin
                    rem_q <= trial;
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted;
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                step_q <= step_q - 1'b1;
                if (step_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // R2: a finished division satisfies quotient*divisor + remainder = dividend
    a_r2_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (({{W{1'b0}}, quo_q} * {{W{1'b0}}, dvs_q}) + {{(W-1){1'b0}}, rem_q}
                  == {{W{1'b0}}, dvd_q}));

    // R2: the remainder of a finished division is below the divisor
    a_r2_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (dvs_q != '0)) |-> (rem_q < {1'b0, dvs_q}));

endmodule

// File: rtl/freq_code_conv.sv
// Period-timed frequency to code converter. Debounces the pulse input,
// times whole cycles over at least cfg_min_period clocks, computes the
// frequency in Hz with a shared iterative divider, and maps it onto a
// CODE_W-bit code across the cfg_fmin..cfg_fmax window. Assumes
// cfg_min_period exceeds the 2*(DIV_W+1)+4 clock result latency; a
// measurement or timeout arriving while a result is in progress is dropped.
module freq_code_conv #(
    parameter int CLK_HZ = 200_000_000,
    parameter int DB_W   = 16,
    parameter int TICK_W = 24,
    parameter int CYC_W  = 16,
    parameter int FREQ_W = 24,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_in,
    input  logic [DB_W-1:0]   cfg_debounce,
    input  logic [TICK_W-1:0] cfg_min_period,
    input  logic [TICK_W-1:0] cfg_timeout,
    input  logic [FREQ_W-1:0] cfg_fmin,
    input  logic [FREQ_W-1:0] cfg_fmax,
    output logic [CODE_W-1:0] code,
    output logic              code_valid,
    output logic              under_range,
    output logic              over_range
);

    import fcc_pkg::*;

    localparam int CLK_B  = $clog2(CLK_HZ + 1);
    localparam int PROD_W = CYC_W + CLK_B;
    localparam int SCL_W  = FREQ_W + CODE_W;
    localparam int DIV_W  = (PROD_W > SCL_W) ? PROD_W : SCL_W;
    localparam logic [DIV_W-1:0]  CLK_X     = DIV_W'(CLK_HZ);
    localparam logic [CODE_W-1:0] CODE_FULL = '1;
    localparam logic [DIV_W-1:0]  CODE_MAX  = DIV_W'(CODE_FULL);

    logic              db_level;
    logic              db_rise;
    logic              meas_valid;
    logic [CYC_W-1:0]  meas_cycles;
    logic [TICK_W-1:0] meas_ticks;
    logic              timeout_pulse;
    logic              div_go;
    logic [DIV_W-1:0]  div_a;
    logic [DIV_W-1:0]  div_b;
    logic              div_done;
    logic [DIV_W-1:0]  div_q;
    fcc_seq_e          seq;
    logic [CODE_W-1:0] pend_code;
    logic              pend_under;
    logic              pend_over;
    logic [DIV_W-1:0]  fmin_x;
    logic [DIV_W-1:0]  fmax_x;
    logic              unused_bits;

    assign fmin_x      = DIV_W'(cfg_fmin);
    assign fmax_x      = DIV_W'(cfg_fmax);
    assign unused_bits = db_level ^ (^div_q[DIV_W-1:CODE_W]);

    fcc_debounce #(.DB_W(DB_W)) u_debounce (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_in      (pulse_in),
        .hold_cycles (cfg_debounce),
        .level       (db_level),
        .rise        (db_rise)
    );

    fcc_period_meter #(.TICK_W(TICK_W), .CYC_W(CYC_W)) u_meter (
        .clk           (clk),
        .rst_n         (rst_n),
        .rise          (db_rise),
        .min_ticks     (cfg_min_period),
        .timeout_ticks (cfg_timeout),
        .meas_valid    (meas_valid),
        .meas_cycles   (meas_cycles),
        .meas_ticks    (meas_ticks),
        .timeout_pulse (timeout_pulse)
    );

    fcc_divider #(.W(DIV_W)) u_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quotient (div_q)
    );

    // Result sequencer: frequency division, window check, scaling, then publish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq         <= SEQ_IDLE;
            div_go      <= 1'b0;
            div_a       <= '0;
            div_b       <= '0;
            pend_code   <= '0;
            pend_under  <= 1'b0;
            pend_over   <= 1'b0;
            code        <= '0;
            code_valid  <= 1'b0;
            under_range <= 1'b0;
            over_range  <= 1'b0;
        end else begin
            div_go     <= 1'b0;
            code_valid <= 1'b0;
            case (seq)
                SEQ_IDLE: begin
                    if (timeout_pulse) begin
                        pend_code  <= '0;
                        pend_under <= 1'b1;
                        pend_over  <= 1'b0;
                        seq        <= SEQ_OUT;
                    end else if (meas_valid) begin
                        div_a  <= DIV_W'(meas_cycles) * CLK_X;
                        div_b  <= DIV_W'(meas_ticks);
                        div_go <= 1'b1;
                        seq    <= SEQ_FREQ;
                    end
                end
                SEQ_FREQ: begin
                    if (div_done) begin
                        if (div_q < fmin_x) begin
                            pend_code  <= '0;
                            pend_under <= 1'b1;
                            pend_over  <= 1'b0;
                            seq        <= SEQ_OUT;
                        end else if (div_q > fmax_x) begin
                            pend_code  <= CODE_FULL;
                            pend_under <= 1'b0;
                            pend_over  <= 1'b1;
                            seq        <= SEQ_OUT;
                        end else if (fmax_x == fmin_x) begin
                            pend_code  <= '0;
                            pend_under <= 1'b0;
                            pend_over  <= 1'b0;
                            seq        <= SEQ_OUT;
                        end else begin
                            div_a  <= (div_q - fmin_x) * CODE_MAX;
                            div_b  <= fmax_x - fmin_x;
                            div_go <= 1'b1;
                            seq    <= SEQ_SCALE;
                        end
                    end
                end
                SEQ_SCALE: begin
                    if (div_done) begin
                        pend_code  <= div_q[CODE_W-1:0];
                        pend_under <= 1'b0;
                        pend_over  <= 1'b0;
                        seq        <= SEQ_OUT;
                    end
                end
                default: begin
                    code        <= pend_code;
                    under_range <= pend_under;
                    over_range  <= pend_over;
                    code_valid  <= 1'b1;
                    seq         <= SEQ_IDLE;
                end
            endcase
        end
    end

    // R4: under-range always comes with code 0
    a_r4_under_zero: assert property (@(posedge clk) disable iff (!rst_n)
        under_range |-> (code == '0));

    // R5: over-range always comes with the full-scale code
    a_r5_over_full: assert property (@(posedge clk) disable iff (!rst_n)
        over_range |-> (code == CODE_FULL));

    // R3: the two range flags never stand together
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(under_range && over_range));

    // R8: the strobe lasts a single cycle
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid);

    // R8: results move only together with the strobe
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |=> (!$changed(code) && !$changed(under_range) && !$changed(over_range)) || code_valid);

endmodule

// File: tb/tb_freq_code_conv.sv
// Bench: drives pulse trains with chosen periods, chatter and silence, predicts
// each result from the period and configuration, and checks outputs every clock.
module tb_freq_code_conv;

    localparam int  CLK_HZ   = 200_000_000;
    localparam int  CODE_MAX = 4095;
    localparam int  PHASE_TO = 20000;
    localparam int  WDOG     = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse_in = 1'b0;
    logic [15:0] cfg_debounce = 16'd8;
    logic [23:0] cfg_min_period = 24'd1000;
    logic [23:0] cfg_timeout = 24'd4000;
    logic [23:0] cfg_fmin = 24'd1_000_000;
    logic [23:0] cfg_fmax = 24'd3_000_000;
    logic [11:0] code;
    logic        code_valid;
    logic        under_range;
    logic        over_range;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // pulse generator controls
    bit gen_en = 1'b0;
    int gen_p = 100;
    int gen_hi = 50;
    bit gen_glitch = 1'b0;

    // reference model state
    int  skip_n = 0;
    int  got_n = 0;
    int  exp_code = 0;
    bit  exp_under = 1'b0;
    bit  exp_over = 1'b0;
    int  held_code = 0;
    bit  held_under = 1'b0;
    bit  held_over = 1'b0;
    bit  prev_strobe = 1'b0;
    bit  hold_ok = 1'b1;
    bit  monitor_on = 1'b0;
    string cur_req = "R9";

    always #2.5 clk = ~clk;

    freq_code_conv dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .pulse_in       (pulse_in),
        .cfg_debounce   (cfg_debounce),
        .cfg_min_period (cfg_min_period),
        .cfg_timeout    (cfg_timeout),
        .cfg_fmin       (cfg_fmin),
        .cfg_fmax       (cfg_fmax),
        .code           (code),
        .code_valid     (code_valid),
        .under_range    (under_range),
        .over_range     (over_range)
    );

    // Predict the code and flags for a clean train of period p clocks
    task automatic predict(input int p);
        longint n, f, lo, hi;
        n = (longint'(cfg_min_period) + p - 1) / p;
        if (n < 1) n = 1;
        f  = (n * CLK_HZ) / (n * p);
        lo = cfg_fmin;
        hi = cfg_fmax;
        if (f < lo) begin
            exp_code = 0; exp_under = 1; exp_over = 0;
        end else if (f > hi) begin
            exp_code = CODE_MAX; exp_under = 0; exp_over = 1;
        end else if (hi == lo) begin
            exp_code = 0; exp_under = 0; exp_over = 0;
        end else begin
            exp_code = int'(((f - lo) * CODE_MAX) / (hi - lo));
            exp_under = 0; exp_over = 0;
        end
    endtask

    task automatic report_summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Pulse train source, driven away from the active edge
    initial begin
        forever begin
            if (gen_en) begin
                pulse_in = 1'b1;
                repeat (gen_hi) @(negedge clk);
                pulse_in = 1'b0;
                if (gen_glitch) begin
                    repeat (10) @(negedge clk);
                    pulse_in = 1'b1;
                    repeat (3) @(negedge clk);
                    pulse_in = 1'b0;
                    repeat (gen_p - gen_hi - 13) @(negedge clk);
                end else begin
                    repeat (gen_p - gen_hi) @(negedge clk);
                end
            end else begin
                pulse_in = 1'b0;
                @(negedge clk);
            end
        end
    end

    // Per-clock comparison against the reference model, plus watchdog
    always @(negedge clk) begin
        cyc++;
        if (monitor_on) begin
            if (code_valid) begin
                if (prev_strobe) begin
                    failures++;
                    $display("FAIL R8 strobe wider than one cycle: actual=2+ expected=1");
                end
                if (skip_n > 0) begin
                    skip_n--;
                end else begin
                    checks++;
                    if (code != exp_code || under_range != exp_under || over_range != exp_over) begin
                        failures++;
                        $display("FAIL %s code/under/over actual=%0d/%0b/%0b expected=%0d/%0b/%0b",
                                 cur_req, code, under_range, over_range, exp_code, exp_under, exp_over);
                    end
                    got_n++;
                end
                held_code = code; held_under = under_range; held_over = over_range;
            end else if (code != held_code || under_range != held_under || over_range != held_over) begin
                hold_ok = 1'b0;
                failures++;
                $display("FAIL R8 outputs moved without strobe actual=%0d/%0b/%0b expected=%0d/%0b/%0b",
                         code, under_range, over_range, held_code, held_under, held_over);
                held_code = code; held_under = under_range; held_over = over_range;
            end
        end
        prev_strobe = code_valid;
        if (cyc >= WDOG && !finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<%0d cycles", cyc, WDOG);
            report_summary();
        end
    end

    // Run one phase: discard settling results, then require `need` matching results
    task automatic run_phase(input string req, input int skip, input int need);
        int waited;
        cur_req = req;
        skip_n  = skip;
        got_n   = 0;
        hold_ok = 1'b1;
        waited  = 0;
        while (got_n < need && waited < PHASE_TO) begin
            @(negedge clk);
            waited++;
        end
        checks++;
        if (got_n < need) begin
            failures++;
            $display("FAIL %s results seen actual=%0d expected=%0d", req, got_n, need);
        end
        checks++;
        if (!hold_ok) $display("note: %s phase had outputs moving between strobes", req);
    endtask

    initial begin
        // R9: reset state
        repeat (6) @(negedge clk);
        checks++;
        if (code != 0 || code_valid || under_range || over_range) begin
            failures++;
            $display("FAIL R9 reset outputs actual=%0d/%0b/%0b/%0b expected=0/0/0/0",
                     code, code_valid, under_range, over_range);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (code != 0 || code_valid || under_range || over_range) begin
            failures++;
            $display("FAIL R9 post-reset outputs actual=%0d/%0b/%0b/%0b expected=0/0/0/0",
                     code, code_valid, under_range, over_range);
        end
        monitor_on = 1'b1;

        // R2/R3: 2 MHz train in a 1..3 MHz window, mid-scale code
        gen_p = 100; gen_hi = 50; gen_en = 1'b1;
        predict(100);
        run_phase("R2", 2, 3);

        // R1: period not dividing the minimum span, 8 cycles over 1096 clocks
        gen_p = 137; gen_hi = 60;
        predict(137);
        run_phase("R1", 2, 3);

        // R6: short spikes inside the low half are rejected
        gen_p = 100; gen_hi = 50; gen_glitch = 1'b1;
        predict(100);
        run_phase("R6", 2, 3);
        gen_glitch = 1'b0;

        // R4: frequency below the window
        gen_p = 300; gen_hi = 150;
        predict(300);
        run_phase("R4", 2, 3);

        // R5: frequency above the window
        gen_p = 50; gen_hi = 25;
        predict(50);
        run_phase("R5", 2, 3);

        // R3: frequency exactly at the lower edge gives code 0 with no flag
        cfg_fmin = 24'd2_000_000; cfg_fmax = 24'd3_000_000;
        gen_p = 100; gen_hi = 50;
        predict(100);
        run_phase("R3", 2, 3);

        // R3: frequency exactly at the upper edge gives full scale with no flag
        cfg_fmin = 24'd1_000_000; cfg_fmax = 24'd2_000_000;
        predict(100);
        run_phase("R3", 2, 3);

        // R7: silent input reports zero frequency repeatedly
        gen_en = 1'b0;
        exp_code = 0; exp_under = 1; exp_over = 0;
        run_phase("R7", 1, 2);

        // R6: debounce wider than both half-periods accepts no edge at all
        cfg_debounce = 16'd60;
        gen_p = 100; gen_hi = 50; gen_en = 1'b1;
        exp_code = 0; exp_under = 1; exp_over = 0;
        run_phase("R6", 1, 2);

        // R3/R1: recovery after silence, 2.5 MHz in a 1..3 MHz window
        cfg_debounce = 16'd8;
        cfg_fmax = 24'd3_000_000;
        gen_p = 80; gen_hi = 40;
        predict(80);
        run_phase("R3", 2, 3);

        report_summary();
    end

endmodule